// File: doc/BRIEF.md
# Three-Phase Complementary PWM Timer

This block generates three pairs of complementary pulse-width-modulated outputs from a single free-running up-counter. The counter advances on each count-enable strobe and returns to zero after it reaches the value of a period register, so every PWM period spans period+1 counts. Each pair has its own duty register `n`. The normal-phase output of a pair is active while the counter is above `n`, and the counter-phase output is active while the counter is at or below `n`. A fourth output inverts once per period.

Software drives the timer through a small word-wide register port. Through it, software starts and stops counting, picks between a manual stop and an automatic stop at the period boundary, sets the polarity and idle levels, loads period and duty values, reads and writes the counter, and reads and clears event flags. Period and duty values pass through shadow registers: while the timer runs, they take effect only at the next period boundary. A forced-cutoff request drives every PWM output to its idle level at once. The outputs stay idle until software clears the latched cutoff flag.

The run control is a three-state machine. `ST_IDLE` means stopped, with outputs idle. `ST_RUN` means counting with live outputs. `ST_CUT` means counting with outputs forced idle.
- `ST_IDLE` moves on a start write: to `ST_RUN` (*go*), or to `ST_CUT` (*go_cut*) when the cutoff flag is already set.
- `ST_RUN` moves to `ST_CUT` when a cutoff latches (*trip*).
- `ST_CUT` moves to `ST_RUN` when the flag is cleared (*resume*).
- Either running state moves to `ST_IDLE` on a stop write (*halt*), or at a period match in automatic-stop mode (*expire*).

Top module: `cpwm3_timer`

## Requirements
- R1: While running, each count-enable strobe increments the counter. A strobe that finds the counter equal to the period value `m` loads zero instead, so the counter visits 0..m and one period is m+1 strobes.
- R2: For pair i with duty value n (n ≤ m), output `pwm_n[i]` is at its active level for exactly m−n counts of each period, namely while the counter is greater than n.
- R3: For pair i with duty value n (n ≤ m), output `pwm_c[i]` is at its active level for exactly n+1 counts of each period, namely while the counter is at most n. The three pairs use separate duty registers at addresses 3, 4 and 5.
- R4: `pwm_tgl` inverts on each period match and holds its value at all other times. It resets to 0.
- R5: Writing the control register (address 0) with bit 0 = 1 starts counting from the present counter value. Bit 1 selects the stop mode, and bit 2 enables cutoff. A read of address 0 returns the run status in bit 0, together with bits 1 and 2.
- R6: With control bit 1 = 1, a control write with bit 0 = 0 stops counting, and the counter then holds its value; the period match does not stop the timer. With bit 1 = 0, a control write with bit 0 = 0 is ignored.
- R7: With control bit 1 = 0, counting stops by itself at the period match. The run-status bit then reads 0, and the counter reads 0.
- R8: Whenever the timer is stopped, every `pwm_n` bit equals the normal idle level, and every `pwm_c` bit equals the counter idle level.
- R9: The level register (address 1) holds four independent settings: bit 0 is the normal active level, bit 1 the counter active level, bit 2 the normal idle level, and bit 3 the counter idle level. All four are 0 after reset.
- R10: Flag register (address 7) bits are set by events while counting: bit 0 on a period match, bits 1 to 3 on duty matches of pairs 0 to 2, and bit 4 when the counter wraps from all ones without a period match. Writing 1 to a bit clears it.
- R11: Address 6 reads the counter, and a write to address 6 loads it.
- R12: When `cut_req` is high while control bit 2 = 1, all PWM outputs take their idle levels in the same cycle, and flag bit 5 latches. The outputs stay idle until software clears bit 5. When control bit 2 = 0, `cut_req` has no effect.
- R13: Period (address 2) and duty writes go to shadow registers. These are copied to the active compare values every cycle while the timer is stopped, and only at a period match while it runs.
- R14: After reset, the timer is stopped, the counter is 0, and all PWM outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_tick | input | 1 | Count-enable strobe standing in for the count source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for `bus_addr` (combinational) |
| cut_req | input | 1 | Forced-cutoff request |
| pwm_n | output | 3 | Normal-phase outputs, one per pair |
| pwm_c | output | 3 | Counter-phase outputs, one per pair |
| pwm_tgl | output | 1 | Output that inverts once per period |
| evt_flags | output | 6 | Event flags, mirroring the flag register |

## Verification
Some properties hold on every cycle, and the assertions check them there:
- the counter returns to zero after a period match;
- the toggle output inverts only on a period match;
- automatic stop happens at the period match;
- outputs are idle whenever the timer is stopped or a cutoff request is present;
- exactly one output of each pair is active while the outputs are live;
- the overflow flag sets after a wrap.

Other behaviours only show over whole periods or register sequences, so the directed scenarios cover them:
- the exact m−n and n+1 active widths for several duty values and polarities;
- buffered duty updates taking effect one boundary late;
- the ignored stop write in automatic mode;
- cutoff persisting until the flag is cleared;
- write-one-to-clear behaviour.

// File: rtl/cpwm3_pkg.sv
package cpwm3_pkg;
    localparam int NPAIR = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CUT  = 2'd2
    } run_state_t;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_LVL   = 3'd1;
    localparam logic [2:0] A_PER   = 3'd2;
    localparam logic [2:0] A_DUTY0 = 3'd3;
    localparam logic [2:0] A_CNT   = 3'd6;
    localparam logic [2:0] A_FLAG  = 3'd7;

    localparam int F_PER  = 0;
    localparam int F_DUTY = 1;
    localparam int F_OVF  = 4;
    localparam int F_CUT  = 5;
    localparam int NFLAG  = 6;
endpackage

// File: rtl/cpwm3_counter.sv
module cpwm3_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          period_hit,
    output logic          ovf_hit
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    assign period_hit = step && (cnt == period);
    assign ovf_hit    = step && (cnt == CNT_MAX) && (cnt != period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (step) begin
            cnt <= (cnt == period) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cpwm3_phase.sv
module cpwm3_phase #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] duty,
    input  logic          act_n,
    input  logic          act_c,
    input  logic          idle_n,
    input  logic          idle_c,
    input  logic          live,
    output logic          out_n,
    output logic          out_c
);
    logic above;

    always_comb begin
        above = (cnt > duty);
        out_n = live ? (above ? act_n : ~act_n) : idle_n;
        out_c = live ? (above ? ~act_c : act_c) : idle_c;
    end
endmodule

// File: rtl/cpwm3_ctrl.sv
module cpwm3_ctrl
    import cpwm3_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       auto_stop,
    input  logic       period_hit,
    input  logic       cut_flag,
    input  logic       cut_now,
    output run_state_t st,
    output logic       running,
    output logic       live
);
    run_state_t st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (start_req) st_nx = cut_flag ? ST_CUT : ST_RUN;
            end
            ST_RUN: begin
                if (stop_req || (auto_stop && period_hit)) st_nx = ST_IDLE;
                else if (cut_flag)                         st_nx = ST_CUT;
            end
            ST_CUT: begin
                if (stop_req || (auto_stop && period_hit)) st_nx = ST_IDLE;
                else if (!cut_flag)                        st_nx = ST_RUN;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        running = (st != ST_IDLE);
        live    = (st == ST_RUN) && !cut_now;
    end
endmodule

// File: rtl/cpwm3_timer.sv
module cpwm3_timer
    import cpwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_tick,
    input  logic          bus_we,
    input  logic [2:0]    bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic          cut_req,
    output logic [2:0]    pwm_n,
    output logic [2:0]    pwm_c,
    output logic          pwm_tgl,
    output logic [5:0]    evt_flags
);
    logic               stop_by_write;
    logic               cut_en;
    logic [3:0]         lvl;
    logic [CW-1:0]      per_sh, per_act;
    logic [CW-1:0]      duty_sh  [NPAIR];
    logic [CW-1:0]      duty_act [NPAIR];
    logic [NFLAG-1:0]   flags, flag_set, flag_clr;
    logic [CW-1:0]      cnt;
    logic               period_hit, ovf_hit, step, running, live, cut_now;
    logic               ctrl_wr, cnt_ld, reload;
    run_state_t         st;

    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
    assign cnt_ld  = bus_we && (bus_addr == A_CNT);
    assign step    = running && cnt_tick;
    assign cut_now = flags[F_CUT] || (cut_req && cut_en);
    assign reload  = (st == ST_IDLE) || period_hit;

    cpwm3_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (ctrl_wr && bus_wdata[0]),
        .stop_req   (ctrl_wr && !bus_wdata[0] && stop_by_write),
        .auto_stop  (!stop_by_write),
        .period_hit (period_hit),
        .cut_flag   (flags[F_CUT]),
        .cut_now    (cut_now),
        .st         (st),
        .running    (running),
        .live       (live)
    );

    cpwm3_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .ld         (cnt_ld),
        .ld_val     (bus_wdata),
        .period     (per_act),
        .cnt        (cnt),
        .period_hit (period_hit),
        .ovf_hit    (ovf_hit)
    );

    // control, level and period registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_by_write <= 1'b0;
            cut_en        <= 1'b0;
            lvl           <= '0;
            per_sh        <= '0;
            per_act       <= '0;
            pwm_tgl       <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                stop_by_write <= bus_wdata[1];
                cut_en        <= bus_wdata[2];
            end
            if (bus_we && bus_addr == A_LVL) lvl    <= bus_wdata[3:0];
            if (bus_we && bus_addr == A_PER) per_sh <= bus_wdata;
            if (reload)                      per_act <= per_sh;
            pwm_tgl <= pwm_tgl ^ period_hit;
        end
    end

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        localparam logic [2:0] MY_ADDR = A_DUTY0 + 3'(i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                duty_sh[i]  <= '0;
                duty_act[i] <= '0;
            end else begin
                if (bus_we && bus_addr == MY_ADDR) duty_sh[i] <= bus_wdata;
                if (reload)                        duty_act[i] <= duty_sh[i];
            end
        end

        assign flag_set[F_DUTY+i] = step && (cnt == duty_act[i]);

        cpwm3_phase #(.CW(CW)) u_phase (
            .cnt    (cnt),
            .duty   (duty_act[i]),
            .act_n  (lvl[0]),
            .act_c  (lvl[1]),
            .idle_n (lvl[2]),
            .idle_c (lvl[3]),
            .live   (live),
            .out_n  (pwm_n[i]),
            .out_c  (pwm_c[i])
        );
    end

    assign flag_set[F_PER] = period_hit;
    assign flag_set[F_OVF] = ovf_hit;
    assign flag_set[F_CUT] = cut_req && cut_en;
    assign flag_clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata[NFLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    assign evt_flags = flags;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata[2:0] = {cut_en, stop_by_write, running};
            A_LVL:   bus_rdata[3:0] = lvl;
            A_PER:   bus_rdata = per_sh;
            A_CNT:   bus_rdata = cnt;
            A_FLAG:  bus_rdata[NFLAG-1:0] = flags;
            default: bus_rdata = duty_sh[bus_addr - A_DUTY0];
        endcase
    end
endmodule

// File: rtl/cpwm3_timer_sva.sv
module cpwm3_timer_sva
    import cpwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input run_state_t    st,
    input logic [CW-1:0] cnt,
    input logic          period_hit,
    input logic          ovf_hit,
    input logic          stop_by_write,
    input logic          cnt_ld,
    input logic          cut_req,
    input logic          cut_en,
    input logic [3:0]    lvl,
    input logic [2:0]    pwm_n,
    input logic [2:0]    pwm_c,
    input logic          pwm_tgl,
    input logic [5:0]    flags
);
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (period_hit && !cnt_ld) |=> (cnt == '0));

    a_r4_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        period_hit |=> (pwm_tgl != $past(pwm_tgl)));

    a_r4_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !period_hit |=> $stable(pwm_tgl));

    a_r7_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_by_write && period_hit && st != ST_IDLE) |=> (st == ST_IDLE));

    a_r8_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (pwm_n == {3{lvl[2]}} && pwm_c == {3{lvl[3]}}));

    a_r12_cutoff_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_req && cut_en) |-> (pwm_n == {3{lvl[2]}} && pwm_c == {3{lvl[3]}}));

    // R2 and R3: exactly one output of each pair is active while live
    a_r2_one_active: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !(cut_req && cut_en) && !flags[F_CUT]) |->
        (((pwm_n ^ {3{~lvl[0]}}) ^ (pwm_c ^ {3{~lvl[1]}})) == 3'b111));

    a_r10_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> flags[F_OVF]);
endmodule

bind cpwm3_timer cpwm3_timer_sva #(.CW(CW)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (st),
    .cnt           (cnt),
    .period_hit    (period_hit),
    .ovf_hit       (ovf_hit),
    .stop_by_write (stop_by_write),
    .cnt_ld        (cnt_ld),
    .cut_req       (cut_req),
    .cut_en        (cut_en),
    .lvl           (lvl),
    .pwm_n         (pwm_n),
    .pwm_c         (pwm_c),
    .pwm_tgl       (pwm_tgl),
    .flags         (evt_flags)
);

// File: tb/cpwm3_timer_tb.sv
module cpwm3_timer_tb;
    localparam int CLK_P = 10;
    localparam int CW    = 16;
    localparam int M     = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_tick = 1'b1;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic          cut_req = 1'b0;
    logic [2:0]    pwm_n, pwm_c;
    logic          pwm_tgl;
    logic [5:0]    evt_flags;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [3:0] cur_lvl = 4'b0000;

    always #(CLK_P/2) clk = ~clk;

    cpwm3_timer #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cut_req(cut_req), .pwm_n(pwm_n), .pwm_c(pwm_c), .pwm_tgl(pwm_tgl),
        .evt_flags(evt_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // counts active samples of each output over one full period
    task automatic measure(input string req, input int e0, input int e1, input int e2);
        int an [3];
        int ac [3];
        for (int i = 0; i < 3; i++) begin an[i] = 0; ac[i] = 0; end
        for (int s = 0; s <= M; s++) begin
            @(negedge clk);
            #1;
            for (int i = 0; i < 3; i++) begin
                if (pwm_n[i] == cur_lvl[0]) an[i]++;
                if (pwm_c[i] == cur_lvl[1]) ac[i]++;
            end
        end
        chk({req, " R2 normal pair0"}, an[0], M - e0);
        chk({req, " R2 normal pair1"}, an[1], M - e1);
        chk({req, " R2 normal pair2"}, an[2], M - e2);
        chk({req, " R3 counter pair0"}, ac[0], e0 + 1);
        chk({req, " R3 counter pair1"}, ac[1], e1 + 1);
        chk({req, " R3 counter pair2"}, ac[2], e2 + 1);
    endtask

    task automatic set_lvl(input logic [3:0] l);
        cur_lvl = l;
        wr(3'd1, {12'd0, l});
    endtask

    task automatic setup_duties();
        wr(3'd2, CW'(M));
        wr(3'd3, 16'd2);
        wr(3'd4, 16'd5);
        wr(3'd5, 16'd9);
        wr(3'd6, 16'd0);
    endtask

    task automatic t_reset();
        int d;
        chk("R14 reset pwm_n", int'(pwm_n), 0);
        chk("R14 reset pwm_c", int'(pwm_c), 0);
        chk("R4 reset toggle", int'(pwm_tgl), 0);
        rd(3'd0, d); chk("R14 reset ctrl", d, 0);
        rd(3'd6, d); chk("R14 reset count", d, 0);
        rd(3'd1, d); chk("R9 reset levels", d, 0);
    endtask

    task automatic t_duty();
        int d, mx;
        set_lvl(4'b0011);
        setup_duties();
        wr(3'd0, 16'h3);
        rd(3'd0, d); chk("R5 running after start", d & 1, 1);
        mx = 0;
        for (int k = 0; k < 2*(M+1); k++) begin
            rd(3'd6, d);
            if (d > mx) mx = d;
        end
        chk("R1 counter peak equals period", mx, M);
        measure("duty", 2, 5, 9);
        wr(3'd0, 16'h2);
    endtask

    task automatic t_levels();
        set_lvl(4'b0110);
        chk("R8 idle normal level", int'(pwm_n), 7);
        chk("R8 idle counter level", int'(pwm_c), 0);
        wr(3'd0, 16'h3);
        wait_cyc(2);
        measure("R9 levels", 2, 5, 9);
        wr(3'd0, 16'h2);
        #1 chk("R8 stopped normal level", int'(pwm_n), 7);
    endtask

    task automatic t_toggle();
        int changes;
        logic prev;
        set_lvl(4'b0011);
        wr(3'd0, 16'h3);
        @(negedge clk);
        prev = pwm_tgl;
        changes = 0;
        for (int s = 0; s < 3*(M+1); s++) begin
            @(negedge clk);
            if (pwm_tgl != prev) changes++;
            prev = pwm_tgl;
        end
        chk("R4 R1 toggles in three periods", changes, 3);
        wr(3'd0, 16'h2);
    endtask

    task automatic t_auto_stop();
        int d;
        wr(3'd6, 16'd0);
        wr(3'd0, 16'h1);
        wait_cyc(1);
        wr(3'd0, 16'h0);
        rd(3'd0, d); chk("R6 stop write ignored in auto mode", d & 1, 1);
        wait_cyc(2*(M+1));
        rd(3'd0, d); chk("R7 auto stop clears run bit", d & 1, 0);
        rd(3'd6, d); chk("R7 counter zero after auto stop", d, 0);
        chk("R8 auto stop normal idle", int'(pwm_n), 0);
        chk("R8 auto stop counter idle", int'(pwm_c), 0);
    endtask

    task automatic t_manual_stop();
        int d, c1, c2;
        wr(3'd0, 16'h3);
        wait_cyc(3*(M+1));
        rd(3'd0, d); chk("R6 no auto stop in manual mode", d & 1, 1);
        wr(3'd0, 16'h2);
        rd(3'd0, d); chk("R6 manual stop clears run", d & 1, 0);
        rd(3'd6, c1);
        wait_cyc(5);
        rd(3'd6, c2);
        chk("R6 counter holds after stop", c2, c1);
    endtask

    task automatic t_flags();
        int d;
        wr(3'd7, 16'h3F);
        rd(3'd7, d); chk("R10 flags cleared", d, 0);
        wr(3'd0, 16'h3);
        wait_cyc(M + 3);
        wr(3'd0, 16'h2);
        rd(3'd7, d); chk("R10 period and duty flags", d & 15, 15);
        wr(3'd7, 16'h01);
        rd(3'd7, d); chk("R10 write one clears only bit0", d & 15, 14);
    endtask

    task automatic t_overflow();
        int d;
        wr(3'd7, 16'h3F);
        wr(3'd0, 16'h3);
        wr(3'd6, 16'hFFFF);
        wait_cyc(3);
        rd(3'd7, d); chk("R10 overflow flag", (d >> 4) & 1, 1);
        wr(3'd0, 16'h2);
    endtask

    task automatic t_count_rw();
        int d;
        wr(3'd6, 16'd5);
        rd(3'd6, d); chk("R11 counter write/read", d, 5);
    endtask

    task automatic t_buffered();
        int d, bad, tries;
        set_lvl(4'b0011);
        wr(3'd3, 16'd2);
        wr(3'd6, 16'd0);
        wr(3'd0, 16'h3);
        tries = 0;
        d = 0;
        while (d != 3 && tries < 40) begin rd(3'd6, d); tries++; end
        wr(3'd3, 16'd7);
        bad = 0;
        tries = 0;
        rd(3'd6, d);
        while (d != 0 && tries < 40) begin
            if (pwm_n[0] != (d > 2)) bad++;
            rd(3'd6, d);
            tries++;
        end
        chk("R13 old duty kept until boundary", bad, 0);
        measure("R13 new duty", 7, 5, 9);
        wr(3'd0, 16'h2);
    endtask

    task automatic t_cutoff();
        int d;
        set_lvl(4'b1100);
        wr(3'd3, 16'd2);
        wr(3'd7, 16'h3F);
        wr(3'd0, 16'h7);
        wait_cyc(3);
        @(negedge clk);
        cut_req = 1'b1;
        #1;
        chk("R12 cutoff normal idle at once", int'(pwm_n), 7);
        chk("R12 cutoff counter idle at once", int'(pwm_c), 7);
        @(negedge clk);
        cut_req = 1'b0;
        wait_cyc(5);
        chk("R12 cutoff persists normal", int'(pwm_n), 7);
        chk("R12 cutoff persists counter", int'(pwm_c), 7);
        rd(3'd7, d); chk("R12 cutoff flag latched", (d >> 5) & 1, 1);
        wr(3'd7, 16'h20);
        @(negedge clk);
        measure("R12 after clear", 2, 5, 9);
        wr(3'd0, 16'h3);
        cut_req = 1'b1;
        measure("R12 cutoff disabled", 2, 5, 9);
        cut_req = 1'b0;
        rd(3'd7, d); chk("R12 no flag when disabled", (d >> 5) & 1, 0);
        wr(3'd0, 16'h2);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_duty();
        t_levels();
        t_toggle();
        t_auto_stop();
        t_manual_stop();
        t_flags();
        t_overflow();
        t_count_rw();
        t_buffered();
        t_cutoff();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule